// File: doc/BRIEF.md
# Processor Clock and Reset Generator

This block turns a single oscillator source into the clocks a small processor system needs. A source selector picks either the crystal-derived oscillator input or an external clock input. The selected source is passed straight through as a buffered oscillator output. It is also divided to make a processor clock at one third of the source rate. That clock is in turn halved to make a peripheral clock.

The same divider timing drives two control paths. An active-low raw reset request is synchronized to the falling edge of the processor clock and stretched into an active-high reset. A group of bus-ready requests is qualified by a matching active-low address-enable for each bus. The OR of the qualified requests is then retimed on the rising edge of the processor clock to form one ready output.

All logic runs from the selected source clock, and the processor-clock edges act as enables. A test-mode asynchronous clear puts every counter and flop into a known phase, so that start-up is deterministic.

Top module: `clkgen_top`

## Requirements
- R1: `osc_out` equals the selected source clock at all times (the crystal input when `src_sel` is 0, the external input when it is 1).
- R2: `proc_clk` is high for one source period and low for DIV-1 source periods (default DIV=3, so a 1/3 rate with a 1/3 duty cycle).
- R3: `per_clk` toggles on every falling edge of `proc_clk`, giving half the processor-clock rate at a 50 % duty cycle.
- R4: With `src_sel`=1 and the crystal input stopped, all outputs run from the external input with the ratios of R2 and R3.
- R5: `rst_out` is active high and changes only at a falling edge of `proc_clk`. After `rst_req_n` goes low, it is high from the 3rd `proc_clk` falling edge.
- R6: After `rst_req_n` returns high, `rst_out` stays high through HOLD_CYC+2 more `proc_clk` falling edges and drops at the (HOLD_CYC+3)-th. This is never fewer than 4 processor cycles (default HOLD_CYC=4).
- R7: Bit i of `rdy_req` counts only while bit i of `bus_en_n` is 0. `ready` is the OR over i of `rdy_req[i] & ~bus_en_n[i]`, and a request on a disabled bus is ignored.
- R8: `ready` changes only at a rising edge of `proc_clk`. It takes the qualified value at the 2nd rising edge after that value is applied.
- R9: While `tst_clr` is high, `proc_clk`=0, `per_clk`=0, `ready`=0 and `rst_out`=1. After `tst_clr` is released, `proc_clk` first rises on the DIV-th source rising edge, and the reset timing of R6 counts from that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal-derived oscillator input |
| ext_clk | input | 1 | External frequency input |
| src_sel | input | 1 | Source select: 0 crystal, 1 external |
| tst_clr | input | 1 | Test-mode asynchronous clear, active high |
| rst_req_n | input | 1 | Raw reset request, active low |
| rdy_req | input | N_BUS | Per-bus ready requests |
| bus_en_n | input | N_BUS | Per-bus address-enables, active low |
| osc_out | output | 1 | Buffered selected source |
| proc_clk | output | 1 | Processor clock, source/DIV |
| per_clk | output | 1 | Peripheral clock, proc_clk/2 |
| rst_out | output | 1 | Synchronized reset, active high |
| ready | output | 1 | Synchronized combined ready |

## Verification
`osc_out` is combinational, so it is sampled 1 ns after a source edge. The clock widths are measured from edge timestamps in nanoseconds. Reset results fall due a fixed number of `proc_clk` falling edges after a change to `rst_req_n`: 3 to assert, and HOLD_CYC+3 to release. The bench therefore counts falling edges from a stimulus applied just after an edge, and samples 1 ns after the edge that is expected to change the output, as well as after the edge before it. The ready sweep applies each of the 16 request and enable patterns just after a `proc_clk` rising edge. It checks that the old value remains after the next rising edge and that the new value appears after the second.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

   // Edge strobes of the processor clock, valid for one source cycle
   typedef struct packed {
      logic rise;   // proc_clk goes high at this source edge
      logic fall;   // proc_clk goes low at this source edge
   } pclk_stb_t;

   localparam int unsigned DEF_DIV        = 3;
   localparam int unsigned DEF_HOLD       = 4;
   localparam int unsigned DEF_SYNC       = 2;
   localparam int unsigned DEF_RDY_STAGES = 2;
   localparam int unsigned DEF_N_BUS      = 2;
   localparam int unsigned MIN_HOLD       = 4;

   function automatic int unsigned cnt_w(input int unsigned maxval);
      int unsigned w;
      w = 1;
      while ((1 << w) <= maxval) w++;
      return w;
   endfunction

endpackage

// File: rtl/clkgen_srcsel.sv
module clkgen_srcsel #(
   parameter bit EXT_SRC_EN = 1'b1
) (
   input  logic xtal_clk,
   input  logic ext_clk,
   input  logic src_sel,
   output logic clk_o
);

   generate
      if (EXT_SRC_EN) begin : g_mux
         assign clk_o = src_sel ? ext_clk : xtal_clk;
      end else begin : g_xtal_only
         logic unused_sel;
         assign unused_sel = src_sel ^ ext_clk;
         assign clk_o      = xtal_clk;
      end
   endgenerate

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
   import clkgen_pkg::*;
#(
   parameter int unsigned DIV = DEF_DIV
) (
   input  logic      clk,
   input  logic      clr,
   output logic      proc_clk,
   output logic      per_clk,
   output pclk_stb_t stb
);

   localparam int unsigned PW = cnt_w(DIV - 1);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] ph_q;
   logic          proc_q;
   logic          per_q;

   // Phase counter; proc_clk is high for the single phase after LAST
   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         ph_q   <= '0;
         proc_q <= 1'b0;
         per_q  <= 1'b0;
      end else begin
         ph_q   <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
         proc_q <= (ph_q == LAST);
         per_q  <= per_q ^ proc_q;
      end
   end

   assign stb.rise = (ph_q == LAST);
   assign stb.fall = proc_q;
   assign proc_clk = proc_q;
   assign per_clk  = per_q;

endmodule

// File: rtl/clkgen_rst.sv
module clkgen_rst
   import clkgen_pkg::*;
#(
   parameter int unsigned SYNC = DEF_SYNC,
   parameter int unsigned HOLD = DEF_HOLD
) (
   input  logic clk,
   input  logic clr,
   input  logic fall_en,
   input  logic req_n,
   output logic rst
);

   localparam int unsigned CW = cnt_w(HOLD);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

   logic [SYNC-1:0] sync_q;
   logic [CW-1:0]   hold_q;
   logic            rst_q;
   logic            req_sync;

   assign req_sync = sync_q[SYNC-1];

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         sync_q <= '1;
         hold_q <= HOLD_V;
         rst_q  <= 1'b1;
      end else if (fall_en) begin
         sync_q <= {sync_q[SYNC-2:0], ~req_n};
         if (req_sync)
            hold_q <= HOLD_V;
         else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
         rst_q  <= req_sync | (hold_q != '0);
      end
   end

   assign rst = rst_q;

endmodule

// File: rtl/clkgen_rdy.sv
module clkgen_rdy
   import clkgen_pkg::*;
#(
   parameter int unsigned N_BUS  = DEF_N_BUS,
   parameter int unsigned STAGES = DEF_RDY_STAGES
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             rise_en,
   input  logic [N_BUS-1:0] rdy_req,
   input  logic [N_BUS-1:0] bus_en_n,
   output logic             ready
);

   logic [N_BUS-1:0]  qual;
   logic              any_req;
   logic [STAGES-1:0] pipe_q;

   generate
      for (genvar i = 0; i < N_BUS; i++) begin : g_qual
         assign qual[i] = rdy_req[i] & ~bus_en_n[i];
      end
   endgenerate

   assign any_req = |qual;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or posedge clr) begin
            if (clr)          pipe_q <= '0;
            else if (rise_en) pipe_q <= any_req;
         end
      end else begin : g_multi
         always_ff @(posedge clk or posedge clr) begin
            if (clr)          pipe_q <= '0;
            else if (rise_en) pipe_q <= {pipe_q[STAGES-2:0], any_req};
         end
      end
   endgenerate

   assign ready = pipe_q[STAGES-1];

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
   import clkgen_pkg::*;
#(
   parameter int unsigned DIV        = DEF_DIV,
   parameter int unsigned HOLD_CYC   = DEF_HOLD,
   parameter int unsigned SYNC       = DEF_SYNC,
   parameter int unsigned RDY_STAGES = DEF_RDY_STAGES,
   parameter int unsigned N_BUS      = DEF_N_BUS,
   parameter bit          EXT_SRC_EN = 1'b1
) (
   input  logic             xtal_clk,
   input  logic             ext_clk,
   input  logic             src_sel,
   input  logic             tst_clr,
   input  logic             rst_req_n,
   input  logic [N_BUS-1:0] rdy_req,
   input  logic [N_BUS-1:0] bus_en_n,
   output logic             osc_out,
   output logic             proc_clk,
   output logic             per_clk,
   output logic             rst_out,
   output logic             ready
);

   // Elaboration-time parameter checks
   generate
      if (DIV < 2) begin : g_bad_div
         $error("clkgen_top: DIV must be at least 2");
      end
      if (SYNC < 2) begin : g_bad_sync
         $error("clkgen_top: SYNC must be at least 2");
      end
      if (HOLD_CYC < MIN_HOLD) begin : g_bad_hold
         $error("clkgen_top: HOLD_CYC below minimum reset width");
      end
      if (RDY_STAGES < 1) begin : g_bad_rdy
         $error("clkgen_top: RDY_STAGES must be at least 1");
      end
      if (N_BUS < 1) begin : g_bad_bus
         $error("clkgen_top: N_BUS must be at least 1");
      end
   endgenerate

   logic      sel_clk;
   pclk_stb_t stb;

   clkgen_srcsel #(.EXT_SRC_EN(EXT_SRC_EN)) u_src (
      .xtal_clk (xtal_clk),
      .ext_clk  (ext_clk),
      .src_sel  (src_sel),
      .clk_o    (sel_clk)
   );

   clkgen_div #(.DIV(DIV)) u_div (
      .clk      (sel_clk),
      .clr      (tst_clr),
      .proc_clk (proc_clk),
      .per_clk  (per_clk),
      .stb      (stb)
   );

   clkgen_rst #(.SYNC(SYNC), .HOLD(HOLD_CYC)) u_rst (
      .clk     (sel_clk),
      .clr     (tst_clr),
      .fall_en (stb.fall),
      .req_n   (rst_req_n),
      .rst     (rst_out)
   );

   clkgen_rdy #(.N_BUS(N_BUS), .STAGES(RDY_STAGES)) u_rdy (
      .clk      (sel_clk),
      .clr      (tst_clr),
      .rise_en  (stb.rise),
      .rdy_req  (rdy_req),
      .bus_en_n (bus_en_n),
      .ready    (ready)
   );

   assign osc_out = sel_clk;

endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
   parameter int unsigned DIV  = 3,
   parameter int unsigned HOLD = 4
) (
   input logic clk,
   input logic tst_clr,
   input logic proc_clk,
   input logic per_clk,
   input logic rst_out,
   input logic rst_req_n,
   input logic ready
);

   logic [15:0] low_run;
   logic [15:0] rel_falls;
   logic        prev_proc;

   always_ff @(posedge clk or posedge tst_clr) begin
      if (tst_clr) begin
         low_run   <= '0;
         rel_falls <= '0;
         prev_proc <= 1'b0;
      end else begin
         prev_proc <= proc_clk;
         if (proc_clk)
            low_run <= '0;
         else if (low_run != 16'hFFFF)
            low_run <= low_run + 16'd1;
         if (!rst_req_n)
            rel_falls <= '0;
         else if (prev_proc && !proc_clk && rel_falls != 16'hFFFF)
            rel_falls <= rel_falls + 16'd1;
      end
   end

   // R2: high for exactly one source period
   a_r2_high_one: assert property (@(posedge clk) disable iff (tst_clr)
      proc_clk |=> !proc_clk);

   // R2: low phase before each rise spans DIV-1 periods (DIV after clear)
   a_r2_low_span: assert property (@(posedge clk) disable iff (tst_clr)
      $rose(proc_clk) |-> (low_run >= 16'(DIV - 1)) && (low_run <= 16'(DIV)));

   // R3: peripheral clock moves only with a processor-clock fall
   a_r3_per_on_fall: assert property (@(posedge clk) disable iff (tst_clr)
      !$stable(per_clk) |-> $fell(proc_clk));

   // R5: reset output moves only with a processor-clock fall
   a_r5_rst_on_fall: assert property (@(posedge clk) disable iff (tst_clr)
      !$stable(rst_out) |-> $fell(proc_clk));

   // R6: reset released only after the minimum width has elapsed
   a_r6_min_width: assert property (@(posedge clk) disable iff (tst_clr)
      $fell(rst_out) |-> (rel_falls >= 16'(HOLD)));

   // R8: ready moves only with a processor-clock rise
   a_r8_rdy_on_rise: assert property (@(posedge clk) disable iff (tst_clr)
      !$stable(ready) |-> $rose(proc_clk));

endmodule

bind clkgen_top clkgen_chk #(.DIV(DIV), .HOLD(HOLD_CYC)) u_chk (
   .clk       (sel_clk),
   .tst_clr   (tst_clr),
   .proc_clk  (proc_clk),
   .per_clk   (per_clk),
   .rst_out   (rst_out),
   .rst_req_n (rst_req_n),
   .ready     (ready)
);

// File: tb/test_clkgen_top.sv
`timescale 1ns/1ps
module test_clkgen_top;

   localparam int DIV  = 3;
   localparam int HOLD = 4;

   logic       xtal_clk = 1'b0;
   logic       ext_clk  = 1'b0;
   logic       xtal_run = 1'b1;
   logic       ext_run  = 1'b0;
   logic       src_sel, tst_clr, rst_req_n;
   logic [1:0] rdy_req, bus_en_n;
   logic       osc_out, proc_clk, per_clk, rst_out, ready;

   int total = 0;
   int bad   = 0;

   // 250 MHz crystal-side clock, slower external clock
   always #2 xtal_clk = xtal_run ? ~xtal_clk : 1'b0;
   always #3 ext_clk  = ext_run  ? ~ext_clk  : 1'b0;

   clkgen_top i_clkgen_top (
      .xtal_clk (xtal_clk), .ext_clk (ext_clk), .src_sel (src_sel),
      .tst_clr (tst_clr), .rst_req_n (rst_req_n), .rdy_req (rdy_req),
      .bus_en_n (bus_en_n), .osc_out (osc_out), .proc_clk (proc_clk),
      .per_clk (per_clk), .rst_out (rst_out), .ready (ready)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(input int base, input string req);
      time t_r, t_f, t_r2, p_r, p_f, p_r2;
      @(posedge proc_clk); t_r = $time;
      @(negedge proc_clk); t_f = $time;
      @(posedge proc_clk); t_r2 = $time;
      chk({req, " proc high"}, 32'(t_f - t_r), 32'(base));
      chk({req, " proc period"}, 32'(t_r2 - t_r), 32'(base * DIV));
      @(posedge per_clk); p_r = $time;
      @(negedge per_clk); p_f = $time;
      @(posedge per_clk); p_r2 = $time;
      chk({req, " per high"}, 32'(p_f - p_r), 32'(base * DIV));
      chk({req, " per period"}, 32'(p_r2 - p_r), 32'(base * DIV * 2));
   endtask

   task automatic wait_falls(input int n);
      for (int i = 0; i < n; i++) @(negedge proc_clk);
      #1;
   endtask

   initial begin
      #800000;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      src_sel = 1'b0; tst_clr = 1'b1; rst_req_n = 1'b1;
      rdy_req = 2'b00; bus_en_n = 2'b11;
      #11;
      // R9: state under clear
      chk("R9 proc under clear", 32'(proc_clk), 0);
      chk("R9 per under clear", 32'(per_clk), 0);
      chk("R9 ready under clear", 32'(ready), 0);
      chk("R9 rst under clear", 32'(rst_out), 1);
      @(negedge xtal_clk); tst_clr = 1'b0;
      n = 0;
      for (int i = 0; i < 10; i++) begin
         @(posedge xtal_clk); #1; n++;
         if (proc_clk) break;
      end
      chk("R9 first proc rise edge", 32'(n), 32'(DIV));
      // R6/R9: reset width counted from the clear release
      wait_falls(HOLD + 2);
      chk("R6 rst held after clear", 32'(rst_out), 1);
      wait_falls(1);
      chk("R6 rst drop after clear", 32'(rst_out), 0);

      // R1: buffered oscillator follows crystal
      @(posedge xtal_clk); #1;
      chk("R1 osc high", 32'(osc_out), 1);
      #2;
      chk("R1 osc low", 32'(osc_out), 0);
      // R2/R3: crystal-rate ratios
      measure(4, "R2/R3 xtal");

      // R5: assert request just after a fall
      @(negedge proc_clk); @(negedge xtal_clk); rst_req_n = 1'b0;
      wait_falls(2);
      chk("R5 rst not yet", 32'(rst_out), 0);
      wait_falls(1);
      chk("R5 rst asserted", 32'(rst_out), 1);
      #5;
      chk("R5 rst steady between falls", 32'(rst_out), 1);
      wait_falls(3);
      @(negedge xtal_clk); rst_req_n = 1'b1;
      wait_falls(HOLD + 2);
      chk("R6 rst held after release", 32'(rst_out), 1);
      wait_falls(1);
      chk("R6 rst released", 32'(rst_out), 0);

      // R7/R8: sweep all request/enable patterns
      begin
         logic prev_exp, exp;
         prev_exp = 1'b0;
         for (int k = 0; k < 16; k++) begin
            @(posedge proc_clk); @(negedge xtal_clk);
            rdy_req  = 2'(k);
            bus_en_n = 2'(k >> 2);
            exp = |(rdy_req & ~bus_en_n);
            @(posedge proc_clk); #1;
            chk($sformatf("R8 ready hold pattern %0d", k), 32'(ready), 32'(prev_exp));
            @(posedge proc_clk); #1;
            chk($sformatf("R7 ready pattern %0d", k), 32'(ready), 32'(exp));
            prev_exp = exp;
         end
      end

      // R4: switch to the external source with crystal stopped
      tst_clr = 1'b1;
      #5;
      src_sel = 1'b1; ext_run = 1'b1; xtal_run = 1'b0;
      #20;
      @(negedge ext_clk); tst_clr = 1'b0;
      @(posedge ext_clk); #1;
      chk("R4 osc follows ext high", 32'(osc_out), 1);
      chk("R1 osc equals ext", 32'(osc_out == ext_clk), 1);
      #3;
      chk("R4 osc follows ext low", 32'(osc_out), 0);
      measure(6, "R4 ext");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule